// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave-side transaction engine of a small byte-addressed serial memory that sits on a two-wire bus. SCL and SDA arrive already synchronised to the system clock. START and STOP arrive as one-cycle strobes from a separate bus-condition detector. The engine drives a single pull-down enable for the open-drain SDA pad. It decodes the control byte and loads the word address into a pointer. It hands each accepted write byte to an external page-buffer and write-cycle controller, and it serves reads from a register array held inside the block.

The pointer is shared by reads and writes. A read begins at the pointer, the pointer advances after every byte, and a sequential read runs through the array and wraps from the last location to zero. Write bytes advance only the low page bits of the pointer, so a long burst wraps inside its page. A STOP that follows at least one complete data byte asks the controller to start its program cycle. The controller raises a busy flag while that cycle runs. During busy the engine acknowledges nothing, and the master can use that to poll for completion.

The controller writes finished data into the array through a dedicated write port. A START or STOP in the middle of a byte drops the transfer, and the engine then waits for a new control byte.

Top module: `tw_mem_slave`

## Requirements
- R1: A control byte is accepted only if bits 7:4 equal 4'b1010. Bits 3:1 are ignored. Bit 0 selects the direction: 1 = read, 0 = write. A byte with any other code in bits 7:4 gets no acknowledge.
- R2: While `busy_i` is high, no acknowledge is driven on any byte, the control byte included. Once `busy_i` is low, a matching control byte is acknowledged again.
- R3: In a write, the byte after the control byte loads the pointer and is acknowledged. Each later byte is acknowledged on the ninth clock and is presented as a one-cycle `wr_req_o` pulse carrying the current pointer on `wr_addr_o` and the byte on `wr_data_o`.
- R4: After each write data byte, the low 3 bits of the pointer (PAGE_W) increment and wrap inside the page, and the upper bits stay unchanged.
- R5: A STOP on a byte boundary after at least one accepted data byte produces exactly one `wr_go_o` pulse. A repeated START, or a STOP after a write that carried no data, produces none.
- R6: A current-address read returns the byte at the pointer. The pointer then holds the last location accessed plus one, whether that access was a read or a write.
- R7: A random read works as follows: a write carrying only the address, then a repeated START, then a read control byte. It returns the byte at that address.
- R8: When the master acknowledges a read byte, the next sequential byte follows. The pointer wraps from the last location of the array back to 0.
- R9: When the master does not acknowledge a read byte, SDA is released and stays released until the next START.
- R10: Read bits are sent MSB first. The pull-down changes only while SCL is low, except that it is released on START or STOP, and it is held through the whole SCL-high phase of the ninth clock.
- R11: A START or STOP before a byte is complete aborts that byte. No `wr_req_o` or `wr_go_o` results, and a following control byte is decoded normally.
- R12: The array resets to all zeros, and a byte written through `arr_we_i`/`arr_addr_i`/`arr_data_i` is returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| start_i | input | 1 | One-cycle START strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| sda_pull_o | output | 1 | Pull-down enable for the open-drain SDA pad |
| busy_i | input | 1 | Write cycle in progress, from the controller |
| wr_req_o | output | 1 | One-cycle pulse: a write byte was accepted |
| wr_addr_o | output | ADDR_W | Target address of the accepted byte |
| wr_data_o | output | 8 | Accepted write byte |
| wr_go_o | output | 1 | One-cycle pulse: start the program cycle |
| arr_we_i | input | 1 | Array write enable from the controller |
| arr_addr_i | input | ADDR_W | Array write address |
| arr_data_i | input | 8 | Array write data |

## Verification
A corrupted bit counter shows up within one byte time as an acknowledge on the wrong SCL pulse, or as a missing one, seen on the sampled SDA line. A wrong pointer shows up in the first data byte of the next current-address or sequential read, or on `wr_addr_o` in the cycle after the eighth SCL fall of a data byte, which is where a bad page wrap becomes visible. A stale abort or commit flag shows up as an extra or missing `wr_go_o` pulse just after the STOP, and the busy window it opens makes the next control byte go unacknowledged.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA
   } tws_state_e;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned CNT_W    = 4;
   localparam int unsigned SLOT_POS = 8;   // SCL rises per byte before the ninth clock
endpackage

// File: rtl/tws_edges.sv
module tws_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   output logic rise_o,
   output logic fall_o
);
   logic scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_i;
   end

   assign rise_o = scl_i & ~scl_q;
   assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/tws_array.sv
module tws_array #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter bit          RESET_MEM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (RESET_MEM) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we_i) begin
               mem[waddr_i] <= wdata_i;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we_i) mem[waddr_i] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
   import tws_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PAGE_W    = 3,
   parameter logic [3:0]  DEV_CODE  = 4'b1010,
   parameter bit          RESET_MEM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              start_i,
   input  logic              stop_i,
   output logic              sda_pull_o,
   input  logic              busy_i,
   output logic              wr_req_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_go_o,
   input  logic              arr_we_i,
   input  logic [ADDR_W-1:0] arr_addr_i,
   input  logic [7:0]        arr_data_i
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SLOT_POS);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   generate
      if (ADDR_W < 2 || ADDR_W > BYTE_W) begin : g_bad_aw
         $error("ADDR_W must lie in 2..8");
      end
      if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_pw
         $error("PAGE_W must lie in 1..ADDR_W");
      end
   endgenerate

   tws_state_e          st;
   logic [CNT_W-1:0]    cnt;
   logic                nine;
   logic [BYTE_W-1:0]   sh;
   logic [BYTE_W-2:0]   tx;
   logic                pull;
   logic                ack_drv;
   logic                acked;
   logic                is_rd;
   logic                mack;
   logic                wr_pend;
   logic [ADDR_W-1:0]   ptr;
   logic [ADDR_W-1:0]   ptr_pg_inc;
   logic [ADDR_W-1:0]   ptr_lin_inc;
   logic [BYTE_W-1:0]   rd_byte;
   logic                scl_rise;
   logic                scl_fall;
   logic                ctrl_hit;
   logic                on_boundary;

   tws_edges u_edges (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_i),
      .rise_o (scl_rise),
      .fall_o (scl_fall)
   );

   tws_array #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (BYTE_W),
      .RESET_MEM (RESET_MEM)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (arr_we_i),
      .waddr_i (arr_addr_i),
      .wdata_i (arr_data_i),
      .raddr_i (ptr),
      .rdata_o (rd_byte)
   );

   // pointer advance: linear for reads, page-local for writes
   assign ptr_lin_inc = ptr + ADDR_W'(1);
   generate
      if (PAGE_W == ADDR_W) begin : g_pg_full
         assign ptr_pg_inc = ptr_lin_inc;
      end else begin : g_pg_part
         assign ptr_pg_inc = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
      end
   endgenerate

   assign ctrl_hit    = (sh[7:4] == DEV_CODE) && !busy_i;
   assign on_boundary = (cnt <= CNT_ONE) && !nine;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         nine      <= 1'b0;
         sh        <= '0;
         tx        <= '0;
         pull      <= 1'b0;
         ack_drv   <= 1'b0;
         acked     <= 1'b0;
         is_rd     <= 1'b0;
         mack      <= 1'b0;
         wr_pend   <= 1'b0;
         ptr       <= '0;
         wr_req_o  <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
         wr_go_o   <= 1'b0;
      end else begin
         wr_req_o <= 1'b0;
         wr_go_o  <= 1'b0;
         if (start_i) begin
            // repeated START closes any write without a program cycle
            st      <= ST_CTRL;
            cnt     <= '0;
            nine    <= 1'b0;
            pull    <= 1'b0;
            ack_drv <= 1'b0;
            wr_pend <= 1'b0;
         end else if (stop_i) begin
            if (st == ST_WDATA && wr_pend && on_boundary) wr_go_o <= 1'b1;
            st      <= ST_IDLE;
            cnt     <= '0;
            nine    <= 1'b0;
            pull    <= 1'b0;
            ack_drv <= 1'b0;
            wr_pend <= 1'b0;
         end else if (st != ST_IDLE) begin
            if (scl_rise) begin
               if (cnt != CNT_FULL) begin
                  cnt <= cnt + CNT_ONE;
                  if (st != ST_RDATA) sh <= {sh[BYTE_W-2:0], sda_i};
               end else begin
                  nine <= 1'b1;
                  mack <= !sda_i;
               end
            end else if (scl_fall) begin
               if (nine) begin
                  // end of the ninth clock
                  cnt     <= '0;
                  nine    <= 1'b0;
                  ack_drv <= 1'b0;
                  pull    <= 1'b0;
                  unique case (st)
                     ST_CTRL: begin
                        if (!acked) begin
                           st <= ST_IDLE;
                        end else if (is_rd) begin
                           st   <= ST_RDATA;
                           tx   <= rd_byte[BYTE_W-2:0];
                           pull <= !rd_byte[BYTE_W-1];
                           ptr  <= ptr_lin_inc;
                        end else begin
                           st <= ST_ADDR;
                        end
                     end
                     ST_ADDR:  st <= acked ? ST_WDATA : ST_IDLE;
                     ST_WDATA: if (!acked) st <= ST_IDLE;
                     ST_RDATA: begin
                        if (mack) begin
                           tx   <= rd_byte[BYTE_W-2:0];
                           pull <= !rd_byte[BYTE_W-1];
                           ptr  <= ptr_lin_inc;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end
                     default: st <= ST_IDLE;
                  endcase
               end else if (cnt == CNT_FULL) begin
                  // eighth bit done: decide the acknowledge
                  unique case (st)
                     ST_CTRL: begin
                        is_rd   <= sh[0];
                        acked   <= ctrl_hit;
                        pull    <= ctrl_hit;
                        ack_drv <= ctrl_hit;
                     end
                     ST_ADDR: begin
                        acked   <= !busy_i;
                        pull    <= !busy_i;
                        ack_drv <= !busy_i;
                        if (!busy_i) ptr <= sh[ADDR_W-1:0];
                     end
                     ST_WDATA: begin
                        acked   <= !busy_i;
                        pull    <= !busy_i;
                        ack_drv <= !busy_i;
                        if (!busy_i) begin
                           wr_req_o  <= 1'b1;
                           wr_addr_o <= ptr;
                           wr_data_o <= sh;
                           ptr       <= ptr_pg_inc;
                           wr_pend   <= 1'b1;
                        end
                     end
                     ST_RDATA: pull <= 1'b0;
                     default:  pull <= 1'b0;
                  endcase
               end else if (st == ST_RDATA && cnt != '0) begin
                  pull <= !tx[BYTE_W-2];
                  tx   <= {tx[BYTE_W-3:0], 1'b0};
               end
            end
         end
      end
   end

   assign sda_pull_o = pull;

   // R10: the pull-down moves only with SCL low, or on a START/STOP release
   a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull_o != $past(sda_pull_o)) |-> (!$past(scl_i) || $past(start_i) || $past(stop_i)));

   // R2: an acknowledge is never opened while the write cycle is busy
   a_r2_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_drv) |-> !$past(busy_i));

   // R5: a program request follows only a STOP
   a_r5_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go_o |-> $past(stop_i));

   // R11: START and STOP always leave SDA released
   a_r11_start_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start_i) || $past(stop_i)) |-> !sda_pull_o);

   // R3: a write request never coincides with an active read
   a_r3_req_not_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> !$past(is_rd && st == ST_RDATA));
endmodule

// File: tb/sim_tw_mem_slave.sv
module sim_tw_mem_slave;
   localparam int CLK_P = 10;
   localparam int BUSY  = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1, start_s = 1'b0, stop_s = 1'b0;
   logic busy = 1'b0, arr_we = 1'b0;
   logic [7:0] arr_addr = '0, arr_data = '0;
   logic sda_pull, wr_req, wr_go;
   logic [7:0] wr_addr, wr_data;
   logic sda_line;

   int nchk = 0, nfail = 0, go_cnt = 0;
   logic [7:0] ref_mem [256];
   logic [7:0] ref_ptr = '0;
   logic [15:0] wq [$];
   logic [15:0] pend [$];
   logic [7:0] rd_q [$];
   string rd_tag [$];
   logic [7:0] rd_got;
   event rd_ev;

   always #(CLK_P/2) clk = ~clk;
   assign sda_line = sda_m & ~sda_pull;

   tw_mem_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .start_i(start_s), .stop_i(stop_s), .sda_pull_o(sda_pull),
      .busy_i(busy), .wr_req_o(wr_req), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .wr_go_o(wr_go), .arr_we_i(arr_we),
      .arr_addr_i(arr_addr), .arr_data_i(arr_data)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: write requests against the expected queue
   initial forever begin
      @(negedge clk);
      if (wr_req) begin
         if (wq.size() == 0) check(0, "R11 unexpected write request", {wr_addr, wr_data}, 0);
         else begin
            logic [15:0] e;
            e = wq.pop_front();
            check({wr_addr, wr_data} == e, "R3/R4 write request", {wr_addr, wr_data}, e);
         end
         pend.push_back({wr_addr, wr_data});
      end
   end

   // monitor: read bytes against the expected queue
   initial forever begin
      @(rd_ev);
      if (rd_q.size() == 0) check(0, "R6 unexpected read byte", rd_got, 0);
      else begin
         logic [7:0] e;
         string t;
         e = rd_q.pop_front();
         t = rd_tag.pop_front();
         check(rd_got == e, t, rd_got, e);
      end
   end

   // model of the page-buffer / write-cycle controller
   initial forever begin
      @(negedge clk);
      if (wr_go) begin
         go_cnt++;
         busy = 1'b1;
         tick(BUSY);
         while (pend.size() != 0) begin
            logic [15:0] p;
            p = pend.pop_front();
            arr_we = 1'b1; arr_addr = p[15:8]; arr_data = p[7:0];
            tick(1);
         end
         arr_we = 1'b0;
         busy = 1'b0;
      end
   end

   task automatic bus_start();
      sda_m = 1'b1; tick(1); scl = 1'b1; tick(2);
      sda_m = 1'b0; start_s = 1'b1; tick(1); start_s = 1'b0; tick(2);
      scl = 1'b0; tick(2);
   endtask

   task automatic bus_stop();
      scl = 1'b0; sda_m = 1'b0; tick(2); scl = 1'b1; tick(2);
      sda_m = 1'b1; stop_s = 1'b1; tick(1); stop_s = 1'b0; tick(3);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         sda_m = b[7-i]; tick(2); scl = 1'b1; tick(3); scl = 1'b0; tick(2);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ak);
      send_bits(b, 8);
      sda_m = 1'b1; tick(2); scl = 1'b1; tick(1);
      ak = !sda_line; tick(2); scl = 1'b0; tick(2);
   endtask

   task automatic recv_byte(input bit mack, input logic [7:0] exp, input string tag);
      logic [7:0] b;
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         tick(2); scl = 1'b1; tick(1); b[7-i] = sda_line; tick(2); scl = 1'b0;
      end
      tick(1); sda_m = !mack; tick(1); scl = 1'b1; tick(3); scl = 1'b0; tick(1); sda_m = 1'b1; tick(1);
      rd_q.push_back(exp); rd_tag.push_back(tag);
      rd_got = b; ->rd_ev;
      tick(1);
   endtask

   task automatic wait_idle();
      tick(3);
      while (busy) tick(1);
      tick(2);
   endtask

   task automatic do_write(input logic [7:0] ctl, input logic [7:0] a, input int n, input logic [7:0] seed);
      bit ak;
      int g0;
      bus_start();
      send_byte(ctl, ak); check(ak, "R1 write control ack", ak, 1);
      send_byte(a, ak);   check(ak, "R3 address ack", ak, 1);
      for (int k = 0; k < n; k++) begin
         logic [7:0] wa, d;
         wa = {a[7:3], 3'(a[2:0] + k)};
         d  = seed + 8'(k * 13);
         wq.push_back({wa, d});
         ref_mem[wa] = d;
         send_byte(d, ak); check(ak, "R3 data ack", ak, 1);
      end
      g0 = go_cnt;
      bus_stop();
      check(go_cnt == g0 + 1, "R5 commit on stop", go_cnt, g0 + 1);
      ref_ptr = {a[7:3], 3'(a[2:0] + n)};
   endtask

   task automatic do_rand_read(input logic [7:0] a, input int n);
      bit ak;
      int g0;
      g0 = go_cnt;
      bus_start();
      send_byte(8'hA0, ak); check(ak, "R7 dummy write ack", ak, 1);
      send_byte(a, ak);     check(ak, "R7 address ack", ak, 1);
      bus_start();
      check(go_cnt == g0, "R5 repeated start no commit", go_cnt, g0);
      send_byte(8'hA1, ak); check(ak, "R7 read control ack", ak, 1);
      for (int k = 0; k < n; k++) recv_byte(k < n - 1, ref_mem[8'(a + k)], "R8 sequential byte");
      check(sda_pull == 1'b0, "R9 release after nack", sda_pull, 0);
      bus_stop();
      ref_ptr = 8'(a + n);
   endtask

   task automatic do_cur_read(input logic [7:0] ctl, input string tag);
      bit ak;
      bus_start();
      send_byte(ctl, ak); check(ak, "R1 read control ack", ak, 1);
      recv_byte(1'b0, ref_mem[ref_ptr], tag);
      check(sda_pull == 1'b0, "R9 release after nack", sda_pull, 0);
      bus_stop();
      ref_ptr = ref_ptr + 8'd1;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = '0;
      tick(4); rst_n = 1'b1; tick(2);
      check(sda_pull == 1'b0, "R12 reset pull released", sda_pull, 0);
      check(wr_req == 1'b0 && wr_go == 1'b0, "R12 reset no requests", {wr_req, wr_go}, 0);

      // R12 reset contents, R6 pointer starts at 0
      do_cur_read(8'hA1, "R12 reset content zero");

      // R3 byte and page write, R5 commit
      do_write(8'hA0, 8'h10, 3, 8'h11);
      // R2 acknowledge polling while busy
      begin
         bit ak;
         int g0;
         g0 = go_cnt;
         check(busy == 1'b1, "R2 controller busy", busy, 1);
         bus_start(); send_byte(8'hA0, ak);
         check(!ak, "R2 no ack while busy", ak, 0);
         bus_stop();
         check(go_cnt == g0, "R5 no commit without data", go_cnt, g0);
         wait_idle();
         bus_start(); send_byte(8'hA0, ak);
         check(ak, "R2 ack after busy", ak, 1);
         bus_stop();
      end
      // R7 random read of the written bytes, R10 MSB-first data
      do_rand_read(8'h10, 3);
      // R6 current read follows the shared pointer
      do_cur_read(8'hA7, "R6 current address read");

      // R1 wrong device code
      begin
         bit ak;
         bus_start(); send_byte(8'hB0, ak);
         check(!ak, "R1 wrong code no ack", ak, 0);
         bus_stop();
         bus_start(); send_byte(8'h21, ak);
         check(!ak, "R1 wrong code read no ack", ak, 0);
         bus_stop();
      end

      // R4 page wrap, don't-care bits in control byte
      do_write(8'hAE, 8'h3E, 10, 8'h40);
      wait_idle();
      do_cur_read(8'hA3, "R6 pointer after page write");
      do_rand_read(8'h38, 8);

      // R8 wrap at end of array
      do_write(8'hA0, 8'hFE, 2, 8'hC5);
      wait_idle();
      do_write(8'hA0, 8'h00, 2, 8'h71);
      wait_idle();
      do_rand_read(8'hFE, 4);

      // R11 START in the middle of a data byte
      begin
         bit ak;
         int g0;
         g0 = go_cnt;
         bus_start();
         send_byte(8'hA0, ak); send_byte(8'h50, ak);
         send_bits(8'hFF, 4);
         bus_start();
         send_byte(8'hA1, ak); check(ak, "R11 control decoded after abort", ak, 1);
         recv_byte(1'b0, ref_mem[8'h50], "R11 pointer kept after start abort");
         bus_stop();
         check(go_cnt == g0, "R11 no commit on start abort", go_cnt, g0);
      end
      // R11 STOP in the middle of a data byte
      begin
         bit ak;
         int g0;
         g0 = go_cnt;
         bus_start();
         send_byte(8'hA0, ak); send_byte(8'h60, ak);
         send_bits(8'h5A, 5);
         bus_stop();
         tick(4);
         check(go_cnt == g0 && busy == 1'b0, "R11 no commit on stop abort", go_cnt, g0);
         ref_ptr = 8'h60;
         do_cur_read(8'hA1, "R11 location untouched");
      end

      check(wq.size() == 0, "R3 all write requests seen", wq.size(), 0);
      check(rd_q.size() == 0, "R6 all reads seen", rd_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule